// File: doc/BRIEF.md
# Trap Vector Address Generator

This block owns the machine trap-vector register of a 32-bit core and turns each trap into the address where fetch resumes. The two low bits of the register select how the target is formed. Direct mode sends every trap to one base. Classic vectored mode spreads interrupts over a table of jump slots, four bytes apart. The interrupt-controller mode reads the target of a selectively vectored interrupt from a table of handler pointers in memory.

Software writes and reads the register through a simple write strobe and a read bus. Illegal mode encodings are dropped, and the register keeps its last legal value. The core raises a one-cycle trap request that carries an interrupt flag, a cause code and the selective-vectoring attribute of the interrupt. An arithmetic target comes back on the next cycle. A table target needs one memory read. The block issues that read on a single-outstanding request port and forwards the returned word when the response arrives. While the read is in flight, the block is busy and refuses further traps.

Top module: `trap_vec_gen`

## Requirements
- R1: After reset, the register reads 0 (direct mode, base 0), and busy, mem_req and tgt_valid are all low.
- R2: A write is discarded and the register keeps its previous value when it requests a reserved encoding. Reserved means wdata[1:0] = 2 with any wdata[5:2], or wdata[1:0] = 3 with wdata[5:2] other than 0.
- R3: A legal write reads back exactly on the next cycle. Legal means wdata[1:0] = 0 or 1, or wdata[1:0] = 3 with wdata[5:2] = 0.
- R4: In mode 0, every accepted trap gives tgt_valid one cycle later, with tgt_pc = {reg[31:2], 2'b00}.
- R5: In mode 1, an accepted interrupt targets {reg[31:2],2'b00} + 4 × cause. An accepted exception targets {reg[31:2],2'b00}. Either target arrives one cycle later.
- R6: In mode 3, an accepted exception, or an interrupt with the attribute bit at 0, targets {reg[31:6], 6'b0} one cycle later, whatever the attribute bit of the exception is.
- R7: In mode 3, an accepted interrupt with the attribute bit at 1 raises mem_req for exactly one cycle, on the next cycle. mem_addr = {reg[31:6],6'b0} + 4 × cause, and busy goes high in that same cycle.
- R8: In the cycle that mem_rvalid is high while busy, tgt_valid is high and tgt_pc equals mem_rdata with bit 0 cleared. Busy drops on the following cycle.
- R9: While busy, a trap request is ignored. While not busy, mem_rvalid has no effect on any output.
- R10: A trap taken in the same cycle as a register write uses the register value from before the write.
- R11: tgt_valid pulses for one cycle per accepted trap and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Current register value |
| trap_req | input | 1 | One-cycle trap request |
| trap_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_cause | input | CAUSE_W | Cause / exception code |
| trap_shv | input | 1 | Selective hardware-vectoring attribute of the interrupt |
| mem_req | output | 1 | Table read request (one-cycle pulse) |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Table read response valid |
| mem_rdata | input | 32 | Table read response data |
| tgt_valid | output | 1 | Target PC valid strobe |
| tgt_pc | output | 32 | Target program counter |
| busy | output | 1 | Table fetch outstanding |

## Verification
The assertions check on every cycle that the register never holds a reserved encoding and that reserved writes leave it unchanged. They also check that each accepted trap yields the target its mode prescribes, that the fetch request is a single pulse with the table address, and that a response is forwarded with bit 0 cleared. Whether stray responses and traps arriving while busy really leave every output untouched over a long run can only be shown by the bench's scenarios. The same holds for the ordering between a write and a trap in the same cycle, and for varied response latencies. There the reference model is compared against the outputs every cycle across directed and random traffic.

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
  parameter int CAUSE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_shv,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               tgt_valid,
  output logic [31:0]        tgt_pc,
  output logic               busy
);

  localparam logic [1:0] M_DIRECT = 2'b00;
  localparam logic [1:0] M_VECT   = 2'b01;
  localparam logic [1:0] M_CTRL   = 2'b11;

  logic [31:0] vec_q;
  logic        busy_q;
  logic        req_q;
  logic [31:0] addr_q;
  logic        av_q;
  logic [31:0] pc_q;

  wire [1:0]  mode       = vec_q[1:0];
  wire [31:0] base_word  = {vec_q[31:2], 2'b00};
  wire [31:0] base_blk   = {vec_q[31:6], 6'b0};
  wire [31:0] cause_off  = 32'(trap_cause) << 2;

  wire [1:0]  w_mode     = csr_wdata[1:0];
  wire        w_legal    = !w_mode[1] || (w_mode == M_CTRL && csr_wdata[5:2] == 4'b0000);

  wire        accept     = trap_req && !busy_q;
  wire        fetch      = accept && mode == M_CTRL && trap_irq && trap_shv;
  wire        resp       = busy_q && mem_rvalid;

  logic [31:0] arith_pc;
  always_comb begin
    case (mode)
      M_DIRECT: arith_pc = base_word;
      M_VECT:   arith_pc = trap_irq ? base_word + cause_off : base_word;
      M_CTRL:   arith_pc = base_blk;
      default:  arith_pc = base_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (csr_we && w_legal) vec_q <= csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      av_q   <= 1'b0;
      pc_q   <= '0;
    end else begin
      req_q <= fetch;
      av_q  <= accept && !fetch;
      if (fetch) begin
        busy_q <= 1'b1;
        addr_q <= base_blk + cause_off;
      end else if (resp) begin
        busy_q <= 1'b0;
      end
      if (accept && !fetch) pc_q <= arith_pc;
    end
  end

  assign csr_rdata = vec_q;
  assign busy      = busy_q;
  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign tgt_valid = av_q || resp;
  assign tgt_pc    = resp ? (mem_rdata & 32'hFFFF_FFFE) : pc_q;

endmodule

// File: rtl/trap_vec_gen_chk.sv
module trap_vec_gen_chk #(
  parameter int CAUSE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csr_we,
  input logic [31:0]        csr_wdata,
  input logic [31:0]        csr_rdata,
  input logic               trap_req,
  input logic               trap_irq,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               trap_shv,
  input logic               mem_req,
  input logic [31:0]        mem_addr,
  input logic               mem_rvalid,
  input logic [31:0]        mem_rdata,
  input logic               tgt_valid,
  input logic [31:0]        tgt_pc,
  input logic               busy
);

  wire        take   = trap_req && !busy;
  wire [31:0] coff   = 32'(trap_cause) << 2;
  wire        w_res  = csr_wdata[1] && !(csr_wdata[1:0] == 2'b11 && csr_wdata[5:2] == 4'b0000);

  p_legal_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1:0] != 2'b10 && (csr_rdata[1:0] != 2'b11 || csr_rdata[5:2] == 4'b0000));

  p_reserved_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && w_res |=> $stable(csr_rdata));

  p_legal_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !w_res |=> csr_rdata == $past(csr_wdata));

  p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && csr_rdata[1:0] == 2'b00 |=> tgt_valid && tgt_pc == {$past(csr_rdata[31:2]), 2'b00});

  p_vectored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && csr_rdata[1:0] == 2'b01 |=>
      tgt_valid && tgt_pc == $past({csr_rdata[31:2], 2'b00} + (trap_irq ? coff : 32'd0)));

  p_ctrl_common_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && csr_rdata[1:0] == 2'b11 && !(trap_irq && trap_shv) |=>
      tgt_valid && tgt_pc == {$past(csr_rdata[31:6]), 6'b0});

  p_fetch_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && csr_rdata[1:0] == 2'b11 && trap_irq && trap_shv |=>
      mem_req && busy && mem_addr == $past({csr_rdata[31:6], 6'b0} + coff));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_resp_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_rvalid |-> tgt_valid && tgt_pc == {mem_rdata[31:1], 1'b0});

  p_resp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_rvalid && !mem_req |=> !busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rvalid |=> busy && !tgt_valid || (busy && mem_rvalid));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !tgt_valid || (busy && mem_rvalid));

endmodule

bind trap_vec_gen trap_vec_gen_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause), .trap_shv(trap_shv),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .tgt_valid(tgt_valid), .tgt_pc(tgt_pc), .busy(busy)
);

// File: tb/test_trap_vec_gen.sv
module test_trap_vec_gen;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic trap_req = 1'b0, trap_irq = 1'b0, trap_shv = 1'b0;
  logic [CW-1:0] trap_cause = '0;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic tgt_valid;
  logic [31:0] tgt_pc;
  logic busy;

  always #5 clk = ~clk;

  trap_vec_gen #(.CAUSE_W(CW)) i_trap_vec_gen (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause), .trap_shv(trap_shv),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tgt_valid(tgt_valid), .tgt_pc(tgt_pc), .busy(busy));

  int n_chk = 0, n_err = 0;

  // reference model state
  logic [31:0] m_reg;
  logic        m_busy, m_av, m_mreq;
  logic [31:0] m_pc, m_maddr;
  string       m_tag;

  function automatic bit legal_wr(logic [31:0] v);
    if (v[1:0] == 2'b10) return 1'b0;
    if (v[1:0] == 2'b11 && v[5:2] != 4'd0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] tbl_word(logic [31:0] a);
    return a * 32'h9E37_79B9 + 32'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_busy = 0; m_av = 0; m_mreq = 0; m_pc = '0; m_maddr = '0; m_tag = "R1";
    end else begin
      automatic bit acc = trap_req && !m_busy;
      automatic logic [31:0] off = 32'(trap_cause) * 4;
      if (m_busy && mem_rvalid) m_busy = 0;
      m_av = 0; m_mreq = 0;
      if (acc) begin
        case (m_reg[1:0])
          2'b00: begin m_av = 1; m_pc = m_reg & 32'hFFFF_FFFC; m_tag = "R4"; end
          2'b01: begin m_av = 1; m_pc = (m_reg & 32'hFFFF_FFFC) + (trap_irq ? off : 0); m_tag = "R5"; end
          default: begin
            if (trap_irq && trap_shv) begin
              m_mreq = 1; m_busy = 1; m_maddr = (m_reg & 32'hFFFF_FFC0) + off; m_tag = "R8";
            end else begin
              m_av = 1; m_pc = m_reg & 32'hFFFF_FFC0; m_tag = "R6";
            end
          end
        endcase
      end
      if (csr_we && legal_wr(csr_wdata)) m_reg = csr_wdata;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // responder and observation
  int          lat_next = 1;
  int          cnt = 0;
  logic [31:0] rd_hold = '0;
  bit          seen_req = 0;
  logic [31:0] seen_addr = '0;
  bit          stray_en = 0;
  bit          last_tv = 0;
  logic [31:0] last_pc = '0;
  int          tv_count = 0;

  task automatic tick();
    logic exp_tv;
    logic [31:0] exp_pc;
    @(negedge clk);
    exp_tv = m_av || (m_busy && mem_rvalid);
    exp_pc = (m_busy && mem_rvalid) ? {mem_rdata[31:1], 1'b0} : m_pc;
    chk(csr_rdata == m_reg, "R2", "csr_rdata", csr_rdata, m_reg);
    chk(busy == m_busy, "R9", "busy", 32'(busy), 32'(m_busy));
    chk(mem_req == m_mreq, "R7", "mem_req", 32'(mem_req), 32'(m_mreq));
    if (m_mreq) chk(mem_addr == m_maddr, "R7", "mem_addr", mem_addr, m_maddr);
    chk(tgt_valid == exp_tv, "R11", "tgt_valid", 32'(tgt_valid), 32'(exp_tv));
    if (exp_tv) chk(tgt_pc == exp_pc, m_tag, "tgt_pc", tgt_pc, exp_pc);
    last_tv = tgt_valid; last_pc = tgt_pc;
    if (tgt_valid) tv_count++;
    seen_req = mem_req; seen_addr = mem_addr;
    @(posedge clk); #1;
    if (seen_req) begin cnt = lat_next; rd_hold = tbl_word(seen_addr); end
    if (cnt > 0) begin
      cnt--;
      mem_rvalid = (cnt == 0);
      mem_rdata  = rd_hold;
    end else begin
      mem_rvalid = stray_en && !m_busy && ($urandom % 3 == 0);
      mem_rdata  = $urandom;
    end
  endtask

  task automatic wr(logic [31:0] v);
    csr_we = 1; csr_wdata = v; tick(); csr_we = 0;
  endtask

  task automatic trap(bit irq, int cause, bit shv);
    trap_req = 1; trap_irq = irq; trap_cause = CW'(cause); trap_shv = shv;
    tick();
    trap_req = 0;
  endtask

  task automatic expect_tgt(logic [31:0] pc, string tag);
    tick();
    chk(last_tv && last_pc == pc, tag, "directed target", last_pc, pc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk(csr_rdata == 0 && !busy && !mem_req && !tgt_valid, "R1", "reset state", csr_rdata, 32'd0);

    // R4 direct
    wr(32'h0000_1234);
    chk(csr_rdata == 32'h0000_1234, "R3", "readback mode0", csr_rdata, 32'h0000_1234);
    trap(1, 9, 1);  expect_tgt(32'h0000_1234, "R4");
    trap(0, 3, 0);  expect_tgt(32'h0000_1234, "R4");

    // R5 vectored
    wr(32'h2000_0101);
    trap(1, 5, 0);  expect_tgt(32'h2000_0114, "R5");
    trap(0, 2, 1);  expect_tgt(32'h2000_0100, "R5");

    // R2 reserved writes
    wr(32'hFFFF_FF02);
    chk(csr_rdata == 32'h2000_0101, "R2", "mode2 dropped", csr_rdata, 32'h2000_0101);
    wr(32'h4000_0007);
    chk(csr_rdata == 32'h2000_0101, "R2", "mode3 sub1 dropped", csr_rdata, 32'h2000_0101);
    wr(32'h4000_003E);
    chk(csr_rdata == 32'h2000_0101, "R2", "mode2 subF dropped", csr_rdata, 32'h2000_0101);

    // R3 controller mode
    wr(32'h8000_0043);
    chk(csr_rdata == 32'h8000_0043, "R3", "readback mode3", csr_rdata, 32'h8000_0043);

    // R6
    trap(1, 7, 0);  expect_tgt(32'h8000_0040, "R6");
    trap(0, 7, 1);  expect_tgt(32'h8000_0040, "R6");

    // R7 R8 with latency 3, R9 trap during busy
    lat_next = 3;
    trap(1, 7, 1);
    chk(mem_req && mem_addr == 32'h8000_005C, "R7", "fetch addr", mem_addr, 32'h8000_005C);
    tv_count = 0;
    trap(1, 1, 0);
    tick(); tick(); tick();
    chk(tv_count == 1, "R9", "one target while busy", 32'(tv_count), 32'd1);
    chk(!busy, "R8", "busy released", 32'(busy), 32'd0);

    // R9 stray responses while idle
    stray_en = 1; tv_count = 0;
    repeat (20) tick();
    chk(tv_count == 0, "R9", "stray rvalid ignored", 32'(tv_count), 32'd0);
    stray_en = 0;

    // R10 write with trap in same cycle
    csr_we = 1; csr_wdata = 32'h0000_0501;
    trap(1, 4, 0); csr_we = 0;
    expect_tgt(32'h8000_0040, "R10");
    chk(csr_rdata == 32'h0000_0501, "R10", "write landed", csr_rdata, 32'h0000_0501);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int k = $urandom % 8;
      lat_next = 1 + $urandom % 4;
      stray_en = ($urandom % 4 == 0);
      if (k == 0) begin
        logic [31:0] v = $urandom;
        if ($urandom % 2 == 0) v[5:0] = {4'd0, 2'b11};
        wr(v);
      end else if (k < 6) begin
        csr_we = ($urandom % 6 == 0); csr_wdata = $urandom;
        trap($urandom % 2, $urandom % 64, $urandom % 2);
        csr_we = 0;
      end else begin
        tick();
      end
    end
    stray_en = 0;
    repeat (8) tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule